// File: doc/BRIEF.md
# Interleaved Dual-Bank Burst Read Controller

This block is the read side of a word-wide memory split into two banks. Even word addresses are in one bank and odd word addresses in the other, and each bank has its own row counter. A start cycle captures a word address and presents that word. Each later read strobe presents the next sequential word. The two counters advance in turn, so reads alternate between the banks. A burst has no length limit and wraps at the top of the address space.

Chip select high puts the block in standby. The data output is disabled, but both counters and the bank selector are kept. Selecting the block again with the address-latch input low resumes the burst where it stopped. Selecting it with the address-latch input high starts a new burst. A start cycle may come at any moment and replaces the burst in progress.

All control inputs are sampled on the rising clock edge. A read advance is triggered by a sampled rising edge of the read strobe. The storage is modelled as two computed read-only arrays, and the default depth is reduced so that the block suits simulation.

Top module: `ilvb_burst_read`

## Requirements
- R1: While reset is low, and in the cycle after it, `dout_oe` is 0 and `dout` is 0. Reset clears both row counters and selects the even bank. The first select cycle with `ale_i` low therefore presents word address 0.
- R2: The word stored at linear word address a, where a = {row, bank bit} and bank bit 0 means even, is the low DATA_W bits of (a * 0x9E37) XOR 0xA5C3.
- R3: When `cs_n` is low and `ale_i` is high at a clock edge with `addr_i[0]` = 0, both counters load `addr_i[AW-1:1]` and the even bank is selected. Right after that edge `dout` shows the word at `addr_i` and `dout_oe` is 1.
- R4: When `cs_n` is low and `ale_i` is high at a clock edge with `addr_i[0]` = 1, the odd counter loads the row and the even counter loads row+1 (modulo the bank depth). The odd bank is selected, and right after that edge `dout` shows the word at `addr_i`.
- R5: An edge where `cs_n` is low, `ale_i` is low, `rd_i` is 1 and `rd_i` was 0 at the previous edge advances the burst. The counter of the bank just shown increments, the other bank is selected, and `dout` shows the word at the next linear address. If `rd_i` stays high, or stays low, the burst does not advance.
- R6: The burst has no length limit. From the last linear address (2^AW - 1), the next advance presents address 0. This also holds for an odd start at the last address, where the even counter wraps to row 0.
- R7: An edge with `cs_n` high drives `dout_oe` and `dout` to 0 from that edge on. It leaves the counters and the bank selector unchanged, even if `rd_i` toggles.
- R8: After standby, an edge with `cs_n` low and `ale_i` low presents again the word that was current when standby began. Later read edges continue from there.
- R9: A start cycle (R3/R4) cancels any burst in progress. It takes priority over a read edge sampled at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; high means standby |
| ale_i | input | 1 | Address latch: high with `cs_n` low starts a burst |
| rd_i | input | 1 | Read strobe; a sampled rising edge advances the burst |
| addr_i | input | AW (ROW_W+1) | Word address; bit 0 picks the bank, upper bits the row |
| dout | output | DATA_W | Presented word, 0 while disabled |
| dout_oe | output | 1 | Output enable for the data bus (0 = high impedance) |

## Verification
On every cycle the assertions check the following. In standby the output is disabled and the burst state is frozen. A start cycle loads the counters according to the parity of the start address. An advance flips the bank selector and steps exactly the counter of the bank just shown. Any other selected cycle leaves the state alone. Only the bench scenarios can show the data itself: the computed array contents, whole bursts that wrap from every start address, resuming at the right word after standby, and a start cycle winning over a coincident read edge.

// File: rtl/ilvb_pkg.sv
// Shared declarations for the interleaved dual-bank burst reader.
// Assumes: the stored data is a computed pattern (no preload files).
package ilvb_pkg;

    // Kind of cycle decoded from the sampled control pins
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,   // selected, no change of position
        CYC_STBY  = 2'd1,   // chip deselected
        CYC_START = 2'd2,   // new burst at captured address
        CYC_ADV   = 2'd3    // read-strobe edge: next word
    } cyc_kind_t;

    // Content of linear word address a (before truncation to data width)
    function automatic logic [31:0] word_pattern(input logic [31:0] a);
        word_pattern = (a * 32'h0000_9E37) ^ 32'h0000_A5C3;
    endfunction

endpackage

// File: rtl/ilvb_cycle_dec.sv
// Decodes the sampled control pins into one cycle kind per clock.
// Assumes: pins are synchronous to clk; a start wins over a read edge.
module ilvb_cycle_dec
    import ilvb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      ale_i,
    input  logic      rd_i,
    output cyc_kind_t kind
);

    logic rd_prev;

    // Remember the strobe level of the previous edge for rise detection
    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= rd_i;
    end

    // Priority decode: standby, then start, then read edge, else idle
    always_comb begin
        if (cs_n)                    kind = CYC_STBY;
        else if (ale_i)              kind = CYC_START;
        else if (rd_i && !rd_prev)   kind = CYC_ADV;
        else                         kind = CYC_IDLE;
    end

endmodule

// File: rtl/ilvb_row_ctr.sv
// Row counter for one bank: loads a start row or steps by one with wrap.
// Assumes: load and step are never requested together by the caller.
module ilvb_row_ctr #(
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic             step,
    output logic [ROW_W-1:0] row
);

    // Hold, load or increment the row; natural overflow wraps to row 0
    always_ff @(posedge clk) begin
        if (!rst_n)    row <= '0;
        else if (load) row <= load_row;
        else if (step) row <= row + 1'b1;
    end

endmodule

// File: rtl/ilvb_bank_rom.sv
// One bank of read-only words, addressed by row; content is computed.
// Assumes: BANK_BIT is the linear-address bit 0 that this bank serves.
module ilvb_bank_rom
    import ilvb_pkg::*;
#(
    parameter int ROW_W    = 5,
    parameter int DATA_W   = 16,
    parameter bit BANK_BIT = 1'b0
) (
    input  logic [ROW_W-1:0]  row,
    output logic [DATA_W-1:0] word
);

    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Fill each row with the pattern of its linear address
    for (genvar r = 0; r < DEPTH; r++) begin : g_cell
        localparam logic [31:0] LIN = (32'(r) << 1) | 32'(BANK_BIT);
        localparam logic [31:0] PAT = word_pattern(LIN);
        assign cells[r] = PAT[DATA_W-1:0];
    end

    // Asynchronous read of the addressed row
    assign word = cells[row];

endmodule

// File: rtl/ilvb_burst_read.sv
// Interleaved dual-bank burst reader: a start cycle captures an address,
// each read-strobe edge presents the next linear word, banks alternate.
// Assumes: synchronous control pins; standby keeps burst position.
module ilvb_burst_read
    import ilvb_pkg::*;
#(
    parameter int ROW_W  = 5,
    parameter int DATA_W = 16,
    localparam int AW    = ROW_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ale_i,
    input  logic              rd_i,
    input  logic [AW-1:0]     addr_i,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    cyc_kind_t         kind;
    logic              sel_q;            // 0: even bank shown, 1: odd
    logic              oe_q;
    logic              start_c;
    logic              adv_c;
    logic [ROW_W-1:0]  start_row;
    logic [ROW_W-1:0]  row_q     [2];
    logic [DATA_W-1:0] bank_word [2];

    ilvb_cycle_dec u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .ale_i (ale_i),
        .rd_i  (rd_i),
        .kind  (kind)
    );

    assign start_c   = (kind == CYC_START);
    assign adv_c     = (kind == CYC_ADV);
    assign start_row = addr_i[AW-1:1];

    // One counter and one array per bank; even loads row+A0, odd loads row
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [ROW_W-1:0] ld_row;
        logic             step_b;

        if (b == 0) begin : g_even
            assign ld_row = start_row + {{(ROW_W-1){1'b0}}, addr_i[0]};
            assign step_b = adv_c && !sel_q;
        end else begin : g_odd
            assign ld_row = start_row;
            assign step_b = adv_c && sel_q;
        end

        ilvb_row_ctr #(.ROW_W(ROW_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (start_c),
            .load_row (ld_row),
            .step     (step_b),
            .row      (row_q[b])
        );

        ilvb_bank_rom #(
            .ROW_W    (ROW_W),
            .DATA_W   (DATA_W),
            .BANK_BIT (b[0])
        ) u_rom (
            .row  (row_q[b]),
            .word (bank_word[b])
        );
    end

    // Bank selector: set from start parity, flipped on each advance
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= 1'b0;
        else if (start_c) sel_q <= addr_i[0];
        else if (adv_c)   sel_q <= !sel_q;
    end

    // Output enable follows the sampled chip select
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= !cs_n;
    end

    // Present the selected bank's word, zero while disabled
    assign dout    = oe_q ? (sel_q ? bank_word[1] : bank_word[0]) : '0;
    assign dout_oe = oe_q;

endmodule

// File: rtl/ilvb_burst_read_chk.sv
// Property checker for the burst reader, attached by bind.
// Assumes: reset is held for at least one edge before use.
module ilvb_burst_read_chk #(
    parameter int ROW_W  = 5,
    parameter int DATA_W = 16,
    localparam int AW    = ROW_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ale_i,
    input logic              rd_i,
    input logic [AW-1:0]     addr_i,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic [ROW_W-1:0]  even_row,
    input logic [ROW_W-1:0]  odd_row,
    input logic              bank_sel
);

    // R7: deselect disables and zeroes the output
    p_standby_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout_oe && dout == '0));

    // R7: deselect freezes the burst state
    p_standby_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(bank_sel) && $stable(even_row) && $stable(odd_row)));

    // R8: selecting the block enables the output
    p_select_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> dout_oe);

    // R3: even start loads both counters with the row, even bank shown
    p_start_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ale_i && !addr_i[0]) |=>
        (!bank_sel && even_row == $past(addr_i[AW-1:1])
                   && odd_row  == $past(addr_i[AW-1:1])));

    // R4: odd start loads odd with row, even with row+1, odd bank shown
    p_start_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ale_i && addr_i[0]) |=>
        (bank_sel && odd_row == $past(addr_i[AW-1:1])
                  && even_row == ROW_W'($past(addr_i[AW-1:1]) + 1'b1)));

    // R5: a read edge flips the bank and steps the even counter when even was shown
    p_adv_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ale_i && rd_i && !$past(rd_i) && !bank_sel) |=>
        (bank_sel && even_row == ROW_W'($past(even_row) + 1'b1)
                  && $stable(odd_row)));

    // R5, R6: a read edge flips the bank and steps the odd counter, wrapping
    p_adv_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ale_i && rd_i && !$past(rd_i) && bank_sel) |=>
        (!bank_sel && odd_row == ROW_W'($past(odd_row) + 1'b1)
                   && $stable(even_row)));

    // R5: selected cycles without a start or read edge change nothing
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ale_i && !(rd_i && !$past(rd_i))) |=>
        ($stable(bank_sel) && $stable(even_row) && $stable(odd_row)));

endmodule

bind ilvb_burst_read ilvb_burst_read_chk #(
    .ROW_W  (ROW_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .ale_i    (ale_i),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .even_row (row_q[0]),
    .odd_row  (row_q[1]),
    .bank_sel (sel_q)
);

// File: tb/ilvb_burst_read_test.sv
`timescale 1ns/100ps
// Sweeping bench for the burst reader: every start address, full wrapping
// bursts, standby/resume, cancellation and start-versus-read priority.
module ilvb_burst_read_test;

    localparam int ROW_W  = 5;
    localparam int DATA_W = 16;
    localparam int AW     = ROW_W + 1;
    localparam int NADDR  = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              ale_i = 1'b0;
    logic              rd_i = 1'b0;
    logic [AW-1:0]     addr_i = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_oe;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // bench model of the burst position
    int  m_addr   = 0;
    bit  m_oe     = 1'b0;
    bit  m_rdprev = 1'b0;

    ilvb_burst_read #(.ROW_W(ROW_W), .DATA_W(DATA_W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .ale_i   (ale_i),
        .rd_i    (rd_i),
        .addr_i  (addr_i),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    always #2.5 clk = ~clk;

    // stored word at a linear address (R2)
    function automatic logic [DATA_W-1:0] pat(input int a);
        logic [31:0] v;
        v = (32'(a) * 32'h9E37) ^ 32'hA5C3;
        return v[DATA_W-1:0];
    endfunction

    task automatic check(input string tag);
        logic [DATA_W-1:0] ed;
        ed = m_oe ? pat(m_addr) : '0;
        n_checks++;
        if (dout_oe !== m_oe || dout !== ed) begin
            n_fails++;
            $display("FAIL %s: oe=%0b dout=%h expected oe=%0b dout=%h (addr %0d)",
                     tag, dout_oe, dout, m_oe, ed, m_addr);
        end
    endtask

    // drive one cycle of pins, clock it, update the model
    task automatic cyc(input bit cs, input bit ale, input bit rd, input int a);
        cs_n = cs; ale_i = ale; rd_i = rd; addr_i = AW'(a);
        @(posedge clk); #1;
        if (cs)                   m_oe = 1'b0;
        else if (ale)           begin m_addr = a % NADDR; m_oe = 1'b1; end
        else if (rd && !m_rdprev) begin m_addr = (m_addr + 1) % NADDR; m_oe = 1'b1; end
        else                      m_oe = 1'b1;
        m_rdprev = rd;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset");
        rst_n = 1'b1;
        check("R1 after reset");
        cyc(0, 0, 0, 0);
        check("R1 first select shows address 0");

        // R2 R3 R4 R5 R6: every start address, bursts past the wrap point
        for (int a = 0; a < NADDR; a++) begin
            cyc(0, 1, 0, a);
            check(a[0] ? "R2 R4 odd start" : "R2 R3 even start");
            for (int k = 0; k < NADDR + 2; k++) begin
                cyc(0, 0, 1, 0);
                check(m_addr == 0 ? "R6 wrap to address 0" : "R5 advance");
                cyc(0, 0, 0, 0);
                check("R5 strobe low holds");
            end
        end

        // R5: strobe held high advances only once
        cyc(0, 1, 0, 10);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 1, 0);
        check("R5 held strobe no advance");
        cyc(0, 0, 0, 0);

        // R7 R8: standby mid-burst with strobe activity, then resume
        cyc(0, 1, 0, 21);
        cyc(0, 0, 1, 0); cyc(0, 0, 0, 0);
        cyc(1, 0, 0, 0);
        check("R7 standby disables output");
        for (int k = 0; k < 4; k++) begin
            cyc(1, 0, 1, 0);
            check("R7 strobe ignored in standby");
            cyc(1, 0, 0, 0);
        end
        cyc(0, 0, 0, 0);
        check("R8 resume same position");
        cyc(0, 0, 1, 0);
        check("R8 resume continues");
        cyc(0, 0, 0, 0);

        // R8 R9: after standby, address latch starts a new burst
        cyc(1, 0, 0, 0);
        cyc(0, 1, 0, NADDR - 1);
        check("R8 R9 new start out of standby");
        cyc(0, 0, 1, 0);
        check("R6 odd start at top wraps to 0");
        cyc(0, 0, 0, 0);

        // R9: start wins over a coincident read edge, cancels burst
        cyc(0, 0, 1, 0); cyc(0, 0, 0, 0);
        cyc(0, 1, 1, 36);
        check("R9 start over read edge");
        cyc(0, 0, 1, 0);
        check("R9 no late advance from held strobe");
        cyc(0, 0, 0, 0);
        cyc(0, 0, 1, 0);
        check("R9 burst continues after start");
        cyc(0, 0, 0, 0);
        cyc(0, 1, 0, 5);
        check("R9 start cancels burst");

        finish_run();
    end

endmodule